// File: doc/BRIEF.md
# Overvoltage Detection Qualifier

This block turns raw per-cell comparator results into a debounced overvoltage fault for a series battery stack of three to five cells. An external cycle timer pulses a one-clock sample strobe once per detection cycle. On each strobe the block reads two flags per cell. One flag says the cell is at or above the detection level. The other says the cell is below the lower release level.

A hit-delay counter raises the fault only after a configured number of consecutive strobes with a hit. The counter survives a lone clean sample between hits and is wiped only by two clean samples in a row. Once the fault is raised, it is dropped only when every active cell sits below the release level, which gives hysteresis between the two levels. A quick-test input shrinks the delay to a single cycle so that board tests run fast. A synchronous clear input, driven by sleep or by a system reset, returns the block to idle.

Top module: `ov_qualifier`

## Requirements
- R1: With an effective delay of D cycles, the fault output goes high right after the D-th consecutive strobe on which any active cell flags a hit. For example, with D = 6 it rises after the sixth such strobe and not before.
- R2: One strobe with no active hit, placed between hit strobes, keeps the accumulated count. Two consecutive strobes with no active hit reset the count to zero.
- R3: While the fault is high, it falls after a strobe on which every active cell flags below-release. It stays high on any other strobe, including strobes with no detection hit.
- R4: Bit 0 of the cell vectors is the lowest cell. With N active cells, only bits 5-N through 4 are used. The activeCells input is clamped to the range 3 to 5. Flags on inactive bits have no effect.
- R5: The effective delay is delayCfg clamped to the range 1 to 14. A delayCfg of 0 acts as 1, and a delayCfg of 15 acts as 14. When quickTest is high the delay is 1 whatever delayCfg holds.
- R6: Comparator flags have no effect unless sampleStb is high. Both outputs change only in the cycle after a strobe or a clear.
- R7: Reset, or a high sleepClr at a clock edge, sets the count and the fault to zero. After this, counting and ovFault are both low.
- R8: counting is high exactly when the hit count is nonzero. The count never exceeds the effective delay. If the delay is lowered below the current count, the next hit strobe raises the fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| sleepClr | input | 1 | Synchronous clear (sleep entry) |
| sampleStb | input | 1 | One-cycle strobe marking a detection cycle |
| ovHit | input | 5 | Per cell: at or above the detection level |
| belowRel | input | 5 | Per cell: below the release level |
| activeCells | input | 3 | Number of cells in use, 3 to 5 |
| delayCfg | input | 4 | Detection delay in cycles |
| quickTest | input | 1 | Forces a one-cycle delay |
| ovFault | output | 1 | Qualified overvoltage fault |
| counting | output | 1 | Hit delay count is nonzero |

## Verification
The bench sweeps every activeCells value from 2 to 6, every delayCfg from 0 to 15 and both quickTest values. Under each setting it drives pseudo-random per-cell levels and compares both outputs after every strobe against an arithmetic model.

Directed runs cover the cases a faulty design would get wrong:
- A design that clears the count on a single clean sample never reaches the fault across a lone gap.
- A design that releases on the detection comparator drops the fault while cells still sit between the two levels.
- A design with a reversed cell mask reacts to flags on unused cells.
- A design that samples between strobes moves its outputs on idle cycles.
- A design that wraps or ignores a lowered delay misses the immediate fault.

// File: rtl/ovq_pkg.sv
package ovq_pkg;
  // commands from control to datapath
  typedef struct packed {
    logic inc;
    logic clr;
  } cntCmd_t;

  // status from datapath to control
  typedef struct packed {
    logic anyHit;
    logic allRel;
    logic reached;
  } cellStat_t;
endpackage

// File: rtl/ovq_datapath.sv
module ovq_datapath
  import ovq_pkg::*;
#(
  parameter int NUM_CELLS = 5,
  parameter int MIN_CELLS = 3,
  parameter int MAX_DELAY = 14,
  localparam int CW = $clog2(NUM_CELLS + 1),
  localparam int DW = $clog2(MAX_DELAY + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_CELLS-1:0] ovHit,
  input  logic [NUM_CELLS-1:0] belowRel,
  input  logic [CW-1:0]        activeCells,
  input  logic [DW-1:0]        delayCfg,
  input  logic                 quickTest,
  input  cntCmd_t              cmd,
  output cellStat_t            stat,
  output logic                 cntNonZero
);
  logic [CW-1:0]        cellsEff;
  logic [DW-1:0]        delayEff;
  logic [NUM_CELLS-1:0] cellMask;
  logic [DW-1:0]        hitCnt;

  always_comb begin
    if (int'(activeCells) < MIN_CELLS)      cellsEff = CW'(MIN_CELLS);
    else if (int'(activeCells) > NUM_CELLS) cellsEff = CW'(NUM_CELLS);
    else                                    cellsEff = activeCells;
  end

  always_comb begin
    if (quickTest)                        delayEff = DW'(1);
    else if (delayCfg == '0)              delayEff = DW'(1);
    else if (int'(delayCfg) > MAX_DELAY)  delayEff = DW'(MAX_DELAY);
    else                                  delayEff = delayCfg;
  end

  // active cells are the top cellsEff bits; lowest ones drop out
  for (genvar i = 0; i < NUM_CELLS; i++) begin : g_mask
    assign cellMask[i] = (i >= (NUM_CELLS - int'(cellsEff)));
  end

  assign stat.anyHit  = |(ovHit & cellMask);
  assign stat.allRel  = &(belowRel | ~cellMask);
  assign stat.reached = ({1'b0, hitCnt} + (DW+1)'(1)) >= {1'b0, delayEff};
  assign cntNonZero   = (hitCnt != '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                          hitCnt <= '0;
    else if (cmd.clr)                   hitCnt <= '0;
    else if (cmd.inc && hitCnt < delayEff) hitCnt <= hitCnt + DW'(1);
  end

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    int'(hitCnt) <= MAX_DELAY);

  assert_inc_clr_excl_R2: assert property (@(posedge clk) disable iff (!rstN)
    !(cmd.inc && cmd.clr));
endmodule

// File: rtl/ovq_control.sv
module ovq_control
  import ovq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      sampleStb,
  input  logic      sleepClr,
  input  cellStat_t stat,
  output cntCmd_t   cmd,
  output logic      fault
);
  logic faultNxt;
  logic cleanPrev, cleanPrevNxt;

  always_comb begin
    faultNxt     = fault;
    cleanPrevNxt = cleanPrev;
    cmd          = '0;
    if (sleepClr) begin
      faultNxt     = 1'b0;
      cleanPrevNxt = 1'b0;
      cmd.clr      = 1'b1;
    end else if (sampleStb) begin
      if (fault) begin
        if (stat.allRel) begin
          faultNxt     = 1'b0;
          cleanPrevNxt = 1'b0;
          cmd.clr      = 1'b1;
        end
      end else if (stat.anyHit) begin
        cleanPrevNxt = 1'b0;
        if (stat.reached) begin
          faultNxt = 1'b1;
          cmd.clr  = 1'b1;
        end else begin
          cmd.inc  = 1'b1;
        end
      end else begin
        if (cleanPrev) cmd.clr = 1'b1;
        cleanPrevNxt = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fault     <= 1'b0;
      cleanPrev <= 1'b0;
    end else begin
      fault     <= faultNxt;
      cleanPrev <= cleanPrevNxt;
    end
  end

  assert_rise_on_hit_R1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fault) |-> $past(sampleStb) && $past(stat.anyHit));

  assert_sleep_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    sleepClr |=> !fault);
endmodule

// File: rtl/ov_qualifier.sv
module ov_qualifier
  import ovq_pkg::*;
#(
  parameter int NUM_CELLS = 5,
  parameter int MIN_CELLS = 3,
  parameter int MAX_DELAY = 14,
  localparam int CW = $clog2(NUM_CELLS + 1),
  localparam int DW = $clog2(MAX_DELAY + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sleepClr,
  input  logic                 sampleStb,
  input  logic [NUM_CELLS-1:0] ovHit,
  input  logic [NUM_CELLS-1:0] belowRel,
  input  logic [CW-1:0]        activeCells,
  input  logic [DW-1:0]        delayCfg,
  input  logic                 quickTest,
  output logic                 ovFault,
  output logic                 counting
);
  cntCmd_t   cmd;
  cellStat_t stat;

  ovq_datapath #(
    .NUM_CELLS(NUM_CELLS), .MIN_CELLS(MIN_CELLS), .MAX_DELAY(MAX_DELAY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ovHit(ovHit), .belowRel(belowRel),
    .activeCells(activeCells), .delayCfg(delayCfg), .quickTest(quickTest),
    .cmd(cmd), .stat(stat), .cntNonZero(counting)
  );

  ovq_control u_ctl (
    .clk(clk), .rstN(rstN), .sampleStb(sampleStb), .sleepClr(sleepClr),
    .stat(stat), .cmd(cmd), .fault(ovFault)
  );

  assert_hold_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
    !sampleStb && !sleepClr |=> $stable(ovFault) && $stable(counting));

  assert_quick_one_R5: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb && !sleepClr && quickTest && !ovFault && stat.anyHit |=> ovFault);

  assert_release_R3: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb && !sleepClr && ovFault && stat.allRel |=> !ovFault && !counting);

  assert_clear_cnt_R7: assert property (@(posedge clk) disable iff (!rstN)
    sleepClr |=> !counting);
endmodule

// File: tb/ov_qualifier_test.sv
module ov_qualifier_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sleepClr = 1'b0;
  logic       sampleStb = 1'b0;
  logic [4:0] ovHit = '0;
  logic [4:0] belowRel = '0;
  logic [2:0] activeCells = 3'd5;
  logic [3:0] delayCfg = 4'd6;
  logic       quickTest = 1'b0;
  logic       ovFault, counting;

  int checks = 0;
  int errors = 0;
  int mCnt = 0;
  bit mFault = 0;
  bit mClean = 0;

  always #4 clk = ~clk;

  ov_qualifier uut (
    .clk(clk), .rstN(rstN), .sleepClr(sleepClr), .sampleStb(sampleStb),
    .ovHit(ovHit), .belowRel(belowRel), .activeCells(activeCells),
    .delayCfg(delayCfg), .quickTest(quickTest),
    .ovFault(ovFault), .counting(counting)
  );

  function automatic int effDelay();
    if (quickTest) return 1;
    if (delayCfg == 0) return 1;
    if (delayCfg > 14) return 14;
    return int'(delayCfg);
  endfunction

  function automatic logic [4:0] cellMask();
    int n = int'(activeCells);
    logic [4:0] m = '0;
    if (n < 3) n = 3;
    if (n > 5) n = 5;
    for (int i = 0; i < 5; i++) m[i] = (i >= 5 - n);
    return m;
  endfunction

  task automatic check(string tag);
    checks++;
    if (ovFault !== mFault || counting !== (mCnt != 0)) begin
      errors++;
      $display("FAIL %s: fault=%b counting=%b expected fault=%b counting=%b",
               tag, ovFault, counting, mFault, (mCnt != 0));
    end
  endtask

  task automatic modelStep();
    logic [4:0] m = cellMask();
    bit hit = |(ovHit & m);
    bit rel = &(belowRel | ~m);
    if (mFault) begin
      if (rel) begin mFault = 0; mCnt = 0; mClean = 0; end
    end else if (hit) begin
      mClean = 0;
      if (mCnt + 1 >= effDelay()) begin mFault = 1; mCnt = 0; end
      else mCnt++;
    end else begin
      if (mClean) mCnt = 0;
      mClean = 1;
    end
  endtask

  task automatic strobe(logic [4:0] h, logic [4:0] r, string tag);
    @(negedge clk);
    ovHit = h; belowRel = r; sampleStb = 1'b1;
    modelStep();
    @(negedge clk);
    sampleStb = 1'b0;
    check(tag);
  endtask

  task automatic clearAll(string tag);
    @(negedge clk);
    sleepClr = 1'b1;
    @(negedge clk);
    sleepClr = 1'b0;
    mCnt = 0; mFault = 0; mClean = 0;
    check(tag);
  endtask

  initial begin
    #400000;
    errors++;
    $display("FAIL watchdog: fault=%b counting=%b expected run end", ovFault, counting);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R7 reset");
    rstN = 1'b1;
    @(negedge clk);
    check("R7 after reset");

    // R1: six hits with delay 6
    for (int k = 0; k < 6; k++) strobe(5'b10000, 5'b00000, "R1 hit run");
    // R3: between levels keeps fault, below release clears
    strobe(5'b00000, 5'b01111, "R3 hold between levels");
    strobe(5'b00000, 5'b11111, "R3 release");

    // R2: lone clean keeps count
    for (int k = 0; k < 5; k++) strobe(5'b01000, 5'b0, "R2 prefill");
    strobe(5'b0, 5'b0, "R2 lone clean");
    strobe(5'b01000, 5'b0, "R2 lone gap hit");
    // R2: two cleans wipe
    strobe(5'b0, 5'b11111, "R3 release again");
    for (int k = 0; k < 5; k++) strobe(5'b00100, 5'b0, "R2 prefill2");
    strobe(5'b0, 5'b0, "R2 clean1");
    strobe(5'b0, 5'b0, "R2 clean2");
    strobe(5'b00100, 5'b0, "R2 restart");

    // R4: unused lowest cells ignored with 3 active
    clearAll("R7 sleep clear");
    activeCells = 3'd3;
    for (int k = 0; k < 8; k++) strobe(5'b00011, 5'b0, "R4 unused hit");
    strobe(5'b00100, 5'b0, "R4 used hit");

    // R6: flags between strobes have no effect
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      ovHit = 5'b11111; belowRel = 5'b11111;
      check("R6 idle");
    end

    // R8: lower the delay below the count
    activeCells = 3'd5;
    clearAll("R7 sleep clear2");
    for (int k = 0; k < 5; k++) strobe(5'b00001, 5'b0, "R8 fill");
    delayCfg = 4'd3;
    strobe(5'b00001, 5'b0, "R8 lowered delay");
    clearAll("R7 sleep clear3");

    // R5: quick test
    quickTest = 1'b1;
    delayCfg = 4'd14;
    strobe(5'b10000, 5'b0, "R5 quick test");
    quickTest = 1'b0;

    // sweep every configuration
    for (int ac = 2; ac <= 6; ac++)
      for (int d = 0; d <= 15; d++)
        for (int q = 0; q <= 1; q++) begin
          activeCells = 3'(ac);
          delayCfg = 4'(d);
          quickTest = q[0];
          clearAll("R7 sweep clear");
          for (int s = 0; s < 30; s++) begin
            logic [4:0] h, r;
            for (int c = 0; c < 5; c++) begin
              int lvl = int'($urandom_range(0, 9));
              h[c] = (lvl >= 5);
              r[c] = (lvl <= 2);
            end
            if (s % 7 == 3) h = '0;
            strobe(h, r, "R1 R2 R3 R4 R5 R8 sweep");
          end
        end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule